// File: doc/BRIEF.md
# SDRAM Mode Register Load Sequencer

This block issues the load-mode commands that program the mode register and the extended mode registers of an attached SDRAM, DDR or DDR2 device while the memory is being initialized. Software reaches it through a small register write port with two registers. A control register holds an enable gate and a programmable command-spacing count. A mode register holds a two-bit bank select, a fourteen-bit value field and a trigger bit. A read port returns the stored contents of either register.

Software first sets the enable gate. It then writes the bank select and the value, either in one write or in separate writes, and sets the trigger. The block drives a single load-mode command on the memory command, bank and address pins. During that command the bank pins carry the bank select and the address pins carry the value field. The block then keeps the commands apart by the programmed spacing. A trigger that arrives during the spacing window waits and is issued when the window closes. To program DDR2, software repeats the trigger four times with bank select 3, 2, 1 and then 0.

Top module: `sdram_mrs_seq`

## Requirements
- R1: After reset the command pins show deselect (cs_n, ras_n, cas_n and we_n all 1), ba and addr are 0, busy and done are 0, the enable bit, the bank select, the value field and the trigger read back 0, and the spacing field reads back 2.
- R2: Registers are written per byte lane. With wr_sel=0 the control register is written: bit 0 is the enable bit (lane 0) and bits 11:8 are the spacing count (lane 1). With wr_sel=1 the mode register is written: bits 13:0 are the value field (bits 7:0 in lane 0, bits 13:8 in lane 1), bits 17:16 are the bank select (lane 2) and bit 24 is the trigger (lane 3). A write that leaves a lane's strobe low does not change that lane, so a write to the value field alone leaves the bank select unchanged. The read port returns the stored fields at the same positions.
- R3: A trigger written while the enable bit is 0 is ignored. No command is issued and the trigger bit reads back 0.
- R4: When the block is not busy, writing the trigger with the enable bit set makes exactly one load-mode command (cs_n, ras_n, cas_n and we_n all 0). The command lasts one cycle and is visible in the cycle after the clock edge that follows the write edge. The trigger bit then reads back 0.
- R5: During the command, ba equals the stored bank select and addr equals the stored value field bit for bit. For example, addr[11:7] carries the operating-mode code (00010 for DLL reset) and addr[6:4] carries the CAS latency.
- R6: Two commands are never closer than max(spacing,1) cycles. A trigger that arrives during the window is held, not lost, and issues exactly at the end of the window.
- R7: busy is 1 in the command cycle and for the rest of the spacing window. done is a one-cycle pulse in the first cycle after each window. The number of done pulses equals the number of commands.
- R8: Four commands triggered in turn with bank select 3, 2, 1 and 0 appear on the pins in that order, each with its own value.
- R9: Clearing the enable bit drops any pending trigger so that no command follows. The pins stay at NOP, and the bank select and the value field keep their stored values.
- R10: In every cycle that is not a command cycle, ba and addr are 0. The command pins show deselect until the enable bit has been set once, and NOP (cs_n 0, the others 1) from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 control, 1 mode |
| wr_be | input | 4 | Byte-lane write strobes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read register select: 0 control, 1 mode |
| rd_data | output | 32 | Contents of the selected register |
| cs_n | output | 1 | Memory chip select, active low |
| ras_n | output | 1 | Memory row strobe, active low |
| cas_n | output | 1 | Memory column strobe, active low |
| we_n | output | 1 | Memory write enable, active low |
| ba | output | 2 | Memory bank pins |
| addr | output | 14 | Memory address pins |
| busy | output | 1 | Command spacing window open |
| done | output | 1 | One-cycle pulse when a window closes |

## Verification
The bench triggers commands while the enable bit is clear. A design that lets such a trigger through would put a stray command on the pins, and the scoreboard reports it as unexpected. It sets a trigger during a long spacing window. A design that drops the trigger would leave an expected item unmatched, and one that issues it early would show a gap shorter than the window. It writes only the value lanes and then reads the bank select back, which catches a design that clobbers the bank bits. It clears the enable bit while a trigger is pending, which exposes a design that fires anyway or that wipes the stored fields. The DDR2 order 3, 2, 1, 0 is checked item by item against the scoreboard queue, so a design that reorders commands or swaps a bank and its value would fail.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

  // Memory command pin group, all active low
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_cmd_t;

  localparam pin_cmd_t CMD_DESEL = 4'b1111;
  localparam pin_cmd_t CMD_NOP   = 4'b0111;
  localparam pin_cmd_t CMD_LMR   = 4'b0000;

  // Field positions in the host-visible registers
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_TMRD_LSB = 8;
  localparam int MODE_BANK_LSB = 16;
  localparam int MODE_TRIG_BIT = 24;

endpackage

// File: rtl/mrs_rst_sync.sv
module mrs_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;

endmodule

// File: rtl/mrs_regfile.sv
module mrs_regfile
  import sdram_mrs_pkg::*;
#(
  parameter int VAL_W    = 14,
  parameter int BA_W     = 2,
  parameter int TMRD_W   = 4,
  parameter int TMRD_RST = 2,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_sel,
  input  logic                launch,
  output logic [DATA_W-1:0]   rd_data,
  output logic                en_q,
  output logic [TMRD_W-1:0]   tmrd_q,
  output logic [BA_W-1:0]     bank_q,
  output logic [VAL_W-1:0]    val_q,
  output logic                trig_q
);

  localparam int LANE_W = 8;

  logic              en_n;
  logic [TMRD_W-1:0] tmrd_n;
  logic [BA_W-1:0]   bank_n;
  logic [VAL_W-1:0]  val_n;
  logic              trig_n;
  logic              wr_ctrl;
  logic              wr_mode;
  logic              upd_en;

  assign wr_ctrl = wr_en && !wr_sel;
  assign wr_mode = wr_en &&  wr_sel;
  assign upd_en  = wr_en || launch || trig_q;

  // Next-state: byte-lane merge, trigger set/clear and enable gating
  always_comb begin
    en_n   = en_q;
    tmrd_n = tmrd_q;
    bank_n = bank_q;
    val_n  = val_q;
    trig_n = trig_q;

    if (launch) begin
      trig_n = 1'b0;
    end

    if (wr_ctrl) begin
      if (wr_be[CTRL_EN_BIT / LANE_W]) begin
        en_n = wr_data[CTRL_EN_BIT];
      end
      for (int i = 0; i < TMRD_W; i++) begin
        if (wr_be[(CTRL_TMRD_LSB + i) / LANE_W]) begin
          tmrd_n[i] = wr_data[CTRL_TMRD_LSB + i];
        end
      end
    end

    if (wr_mode) begin
      for (int i = 0; i < VAL_W; i++) begin
        if (wr_be[i / LANE_W]) begin
          val_n[i] = wr_data[i];
        end
      end
      for (int i = 0; i < BA_W; i++) begin
        if (wr_be[(MODE_BANK_LSB + i) / LANE_W]) begin
          bank_n[i] = wr_data[MODE_BANK_LSB + i];
        end
      end
      if (wr_be[MODE_TRIG_BIT / LANE_W] && wr_data[MODE_TRIG_BIT] && en_q) begin
        trig_n = 1'b1;
      end
    end

    if (!en_n) begin
      trig_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      tmrd_q <= TMRD_W'(TMRD_RST);
      bank_q <= '0;
      val_q  <= '0;
      trig_q <= 1'b0;
    end else if (upd_en) begin
      en_q   <= en_n;
      tmrd_q <= tmrd_n;
      bank_q <= bank_n;
      val_q  <= val_n;
      trig_q <= trig_n;
    end
  end

  // Read-back mux
  always_comb begin
    rd_data = '0;
    if (rd_sel) begin
      rd_data[VAL_W-1:0]              = val_q;
      rd_data[MODE_BANK_LSB +: BA_W]  = bank_q;
      rd_data[MODE_TRIG_BIT]          = trig_q;
    end else begin
      rd_data[CTRL_EN_BIT]            = en_q;
      rd_data[CTRL_TMRD_LSB +: TMRD_W] = tmrd_q;
    end
  end

  AST_BANK_KEPT_ON_VALUE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !wr_be[MODE_BANK_LSB / LANE_W]) |=> $stable(bank_q));  // R2

  AST_TRIG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> en_q);  // R3

endmodule

// File: rtl/mrs_spacing.sv
module mrs_spacing #(
  parameter int TMRD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [TMRD_W-1:0] tmrd,
  output logic              busy,
  output logic              ready,
  output logic              done
);

  logic [TMRD_W-1:0] cnt_q;
  logic [TMRD_W-1:0] cnt_n;
  logic [TMRD_W-1:0] tmrd_eff;
  logic              busy_q;
  logic              busy_n;
  logic              done_q;
  logic              done_n;
  logic              last_cyc;
  logic              cnt_en;

  assign tmrd_eff = (tmrd == '0) ? TMRD_W'(1) : tmrd;
  assign last_cyc = busy_q && (cnt_q == '0);
  assign cnt_en   = launch || busy_q || done_q;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    done_n = last_cyc;
    if (launch) begin
      busy_n = 1'b1;
      cnt_n  = tmrd_eff - TMRD_W'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_n = 1'b0;
      end else begin
        cnt_n = cnt_q - TMRD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign busy  = busy_q;
  assign ready = !busy_q || (cnt_q == '0);
  assign done  = done_q;

  AST_BUSY_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy_q);  // R7

  AST_DONE_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));  // R7

endmodule

// File: rtl/mrs_pin_drive.sv
module mrs_pin_drive
  import sdram_mrs_pkg::*;
#(
  parameter int VAL_W = 14,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             en,
  input  logic [BA_W-1:0]  bank,
  input  logic [VAL_W-1:0] val,
  output pin_cmd_t         cmd,
  output logic [BA_W-1:0]  ba,
  output logic [VAL_W-1:0] addr
);

  pin_cmd_t         cmd_q;
  pin_cmd_t         cmd_n;
  logic [BA_W-1:0]  ba_q;
  logic [BA_W-1:0]  ba_n;
  logic [VAL_W-1:0] addr_q;
  logic [VAL_W-1:0] addr_n;
  logic             armed_q;
  logic             armed_n;

  always_comb begin
    armed_n = armed_q || en;
    if (launch) begin
      cmd_n  = CMD_LMR;
      ba_n   = bank;
      addr_n = val;
    end else begin
      cmd_n  = armed_q ? CMD_NOP : CMD_DESEL;
      ba_n   = '0;
      addr_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_DESEL;
      ba_q    <= '0;
      addr_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      cmd_q   <= cmd_n;
      ba_q    <= ba_n;
      addr_q  <= addr_n;
      armed_q <= armed_n;
    end
  end

  assign cmd  = cmd_q;
  assign ba   = ba_q;
  assign addr = addr_q;

  AST_IDLE_PINS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_LMR) |-> (ba_q == '0 && addr_q == '0));  // R10

endmodule

// File: rtl/sdram_mrs_seq.sv
module sdram_mrs_seq
  import sdram_mrs_pkg::*;
#(
  parameter int VAL_W    = 14,
  parameter int BA_W     = 2,
  parameter int TMRD_W   = 4,
  parameter int TMRD_RST = 2,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_sel,
  output logic [DATA_W-1:0]   rd_data,
  output logic                cs_n,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [BA_W-1:0]     ba,
  output logic [VAL_W-1:0]    addr,
  output logic                busy,
  output logic                done
);

  logic              rst_n_s;
  logic              en_q;
  logic [TMRD_W-1:0] tmrd_q;
  logic [BA_W-1:0]   bank_q;
  logic [VAL_W-1:0]  val_q;
  logic              trig_q;
  logic              ready;
  logic              launch;
  pin_cmd_t          cmd;

  assign launch = trig_q && en_q && ready;

  mrs_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  mrs_regfile #(
    .VAL_W    (VAL_W),
    .BA_W     (BA_W),
    .TMRD_W   (TMRD_W),
    .TMRD_RST (TMRD_RST),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .launch  (launch),
    .rd_data (rd_data),
    .en_q    (en_q),
    .tmrd_q  (tmrd_q),
    .bank_q  (bank_q),
    .val_q   (val_q),
    .trig_q  (trig_q)
  );

  mrs_spacing #(
    .TMRD_W (TMRD_W)
  ) u_space (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .launch (launch),
    .tmrd   (tmrd_q),
    .busy   (busy),
    .ready  (ready),
    .done   (done)
  );

  mrs_pin_drive #(
    .VAL_W (VAL_W),
    .BA_W  (BA_W)
  ) u_pins (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .launch (launch),
    .en     (en_q),
    .bank   (bank_q),
    .val    (val_q),
    .cmd    (cmd),
    .ba     (ba),
    .addr   (addr)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;

  AST_CMD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd == CMD_LMR) |-> $past(en_q));  // R3

  AST_CMD_CARRIES_FIELDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd == CMD_LMR) |-> (ba == $past(bank_q) && addr == $past(val_q)));  // R5

  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd == CMD_LMR && $past(cmd == CMD_LMR)) |-> ($past(tmrd_q) <= TMRD_W'(1)));  // R6

  AST_CMD_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd == CMD_LMR) |-> busy);  // R7

endmodule

// File: tb/tb_sdram_mrs_seq.sv
module tb_sdram_mrs_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [13:0] addr;
  logic        busy, done;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int cmd_cnt = 0;
  int done_cnt = 0;
  int last_cmd_cyc = -1;
  int min_gap = 2;
  bit en_model = 1'b0;
  logic [15:0] exp_q[$];
  int gap_q[$];

  sdram_mrs_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .busy(busy), .done(done)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every command cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (!cs_n && !ras_n && !cas_n && !we_n) begin
        cmd_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected command", {16'h0, ba, addr}, 32'h0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({ba, addr} == e, "R5", "command bank/address", {16'h0, ba, addr}, {16'h0, e});
        end
        if (last_cmd_cyc >= 0) begin
          gap_q.push_back(cyc - last_cmd_cyc);
          chk((cyc - last_cmd_cyc) >= min_gap, "R6", "command gap",
              cyc - last_cmd_cyc, min_gap);
        end
        last_cmd_cyc = cyc;
      end
    end
  end

  task automatic wr(input bit sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic rd(input bit sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic mode_cmd(input logic [1:0] b, input logic [13:0] v, input bit expect_it);
    logic [31:0] r;
    rd(1'b1, r);
    while (r[24]) begin
      @(negedge clk);
      rd(1'b1, r);
    end
    if (expect_it && en_model) exp_q.push_back({b, v});
    wr(1'b1, 4'hF, (32'h1 << 24) | (32'(b) << 16) | 32'(v));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base;
    int g0;

    // R1: reset state
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1", "pins deselect", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
    chk(!busy && !done, "R1", "busy/done low", {busy, done}, 0);
    chk(ba == 0 && addr == 0, "R1", "ba/addr zero", {ba, addr}, 0);
    rd(1'b0, r);
    chk(r == 32'h200, "R1", "control readback", r, 32'h200);
    rd(1'b1, r);
    chk(r == 32'h0, "R1", "mode readback", r, 32'h0);

    // R3: trigger with enable clear is ignored
    mode_cmd(2'd1, 14'h155, 1'b1);
    idle(10);
    chk(cmd_cnt == 0, "R3", "no command while disabled", cmd_cnt, 0);
    rd(1'b1, r);
    chk(r == 32'h0001_0155, "R3", "trigger dropped, fields stored", r, 32'h0001_0155);
    chk(cs_n == 1'b1, "R10", "deselect before first enable", cs_n, 1);

    // R10: enable gives NOP
    wr(1'b0, 4'h3, 32'h201); en_model = 1'b1;
    idle(3);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R10", "NOP after enable", {cs_n, ras_n, cas_n, we_n}, 4'b0111);

    // R2: value lanes only, bank kept
    wr(1'b1, 4'h3, 32'h0002_3FFF);
    rd(1'b1, r);
    chk(r == 32'h0001_3FFF, "R2", "bank kept on value write", r, 32'h0001_3FFF);
    wr(1'b1, 4'h4, 32'h0003_0000);
    rd(1'b1, r);
    chk(r == 32'h0003_3FFF, "R2", "bank lane alone", r, 32'h0003_3FFF);

    // R4/R5/R7: single command, DLL reset op code, CL 3, timing
    mode_cmd(2'd0, 14'h132, 1'b1);
    base = cyc;
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0000, "R4", "command one cycle after trigger edge",
        {cs_n, ras_n, cas_n, we_n}, 4'b0000);
    chk(cyc == base + 1, "R4", "command cycle", cyc, base + 1);
    chk(addr[11:7] == 5'b00010 && addr[6:4] == 3'd3, "R5", "op mode and CAS fields", addr, 14'h132);
    chk(busy == 1'b1, "R7", "busy in command cycle", busy, 1);
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R4", "command lasts one cycle",
        {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(busy && !done, "R7", "busy through window", {busy, done}, 2'b10);
    @(negedge clk);
    chk(!busy && done, "R7", "done pulse after window", {busy, done}, 2'b01);
    @(negedge clk);
    chk(!done, "R7", "done one cycle", done, 0);
    rd(1'b1, r);
    chk(r[24] == 1'b0, "R4", "trigger self-clears", r[24], 0);

    // R8: DDR2 order 3,2,1,0
    base = cmd_cnt;
    mode_cmd(2'd3, 14'h0000, 1'b1);
    mode_cmd(2'd2, 14'h0080, 1'b1);
    mode_cmd(2'd1, 14'h0444, 1'b1);
    mode_cmd(2'd0, 14'h0532, 1'b1);
    idle(10);
    chk(cmd_cnt == base + 4, "R8", "four commands", cmd_cnt, base + 4);
    chk(exp_q.size() == 0, "R8", "sequence fully matched", exp_q.size(), 0);

    // R6: trigger held during long window, issued exactly at its end
    wr(1'b0, 4'h3, 32'h801); min_gap = 8;
    g0 = gap_q.size();
    mode_cmd(2'd1, 14'h00AA, 1'b1);
    while (busy !== 1'b1) @(negedge clk);
    mode_cmd(2'd2, 14'h0055, 1'b1);
    idle(14);
    chk(gap_q.size() == g0 + 2, "R6", "held trigger issued", gap_q.size(), g0 + 2);
    if (gap_q.size() == g0 + 2)
      chk(gap_q[g0 + 1] == 8, "R6", "held trigger gap", gap_q[g0 + 1], 8);

    // R9: clear enable with a pending trigger
    base = cmd_cnt;
    mode_cmd(2'd2, 14'h0044, 1'b1);
    while (busy !== 1'b1) @(negedge clk);
    mode_cmd(2'd3, 14'h00CC, 1'b0);
    wr(1'b0, 4'h3, 32'h800); en_model = 1'b0;
    idle(14);
    chk(cmd_cnt == base + 1, "R9", "pending trigger dropped", cmd_cnt, base + 1);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R9", "pins NOP after disable",
        {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    rd(1'b1, r);
    chk(r == 32'h0003_00CC, "R9", "fields kept", r, 32'h0003_00CC);

    // R6: spacing of one
    wr(1'b0, 4'h3, 32'h101); en_model = 1'b1; min_gap = 1;
    base = cmd_cnt;
    mode_cmd(2'd0, 14'h0011, 1'b1);
    mode_cmd(2'd0, 14'h0022, 1'b1);
    idle(8);
    chk(cmd_cnt == base + 2, "R6", "short spacing commands", cmd_cnt, base + 2);

    chk(exp_q.size() == 0, "R5", "scoreboard empty", exp_q.size(), 0);
    chk(done_cnt == cmd_cnt, "R7", "done pulses per command", done_cnt, cmd_cnt);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule